// File: doc/BRIEF.md
# Sound Generator Host Register File

This block is the host side of a three-voice sound generator. A processor reaches it over one 8-bit multiplexed bus that carries first a register address and then a data byte. Three bus-control inputs pick the operation on each clock: idle, address latch, data write or data read. Behind the bus sit sixteen 8-bit registers. The host can write every one of them and read every one of them back.

The registers feed the tone, noise, mixer, amplitude and envelope logic as decoded fields. Two of the registers are data stores for two general-purpose 8-bit ports. Two bits of the mixer-enable register set the direction of each port. In input mode, a read of a port register returns the live pins. In output mode, the port drives the stored byte.

The bus is split into an input, an output and an output enable. The pad ring builds the tri-state driver from these.

Top module: `sgbus_regfile`

## Requirements
- R1: The control code (busDir,busCtl2,busCtl1) decodes as follows. 1,1,1 latches an address. 1,1,0 writes data. 0,1,1 reads data. 0,1,0 is idle. Every code with busCtl2=0 is idle and has no effect.
- R2: An address latch stores busIn[3:0] as the register address. The block is selected only when busIn[7:4] equals the parameter SEL_CODE (default 0). While deselected, writes are dropped and the bus output is not enabled.
- R3: On the rising edge during a selected write, the addressed register takes busIn, masked to its width.
- R4: During a selected read, busOe is 1 and busOut carries the addressed register in the same cycle. At all other times busOe is 0 and busOut is 0.
- R5: Addresses 1, 3, 5 and 13 keep 4 bits, and addresses 6, 8, 9 and 10 keep 5 bits. The unused high bits of these registers read back as 0. All other registers keep 8 bits.
- R6: In register 7, bit 6 sets the direction of port A and bit 7 sets the direction of port B (1 = output). An output port has portXOe=1 and drives the stored byte of register 14 (port A) or register 15 (port B) on portXOut.
- R7: For a port set to input, a read of its register returns the live portXIn pins. A write still updates the stored byte, and that byte appears once the port is switched to output.
- R8: The sound outputs are decoded as follows. Voice v's tonePeriod is {reg[2v+1][3:0], reg[2v]}. noisePeriod is reg6. mixerEn is reg7[5:0]. ampLevel for voice v is reg[8+v]. envPeriod is {reg12, reg11}. envShape is reg13. Writes to registers 14 and 15 do not change any of these outputs.
- R9: After reset, all registers are 0, the address is 0, the block is selected and the bus is released.
- R10: The latched address persists across any number of following write and read operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low synchronous reset |
| busDir | input | 1 | bus control, direction |
| busCtl2 | input | 1 | bus control, qualifier |
| busCtl1 | input | 1 | bus control, select |
| busIn | input | 8 | address or data from the host |
| busOut | output | 8 | read data to the host |
| busOe | output | 1 | bus drive enable |
| portAIn | input | 8 | port A pins |
| portAOut | output | 8 | port A drive value |
| portAOe | output | 1 | port A drive enable |
| portBIn | input | 8 | port B pins |
| portBOut | output | 8 | port B drive value |
| portBOe | output | 1 | port B drive enable |
| tonePeriod | output | 36 | three 12-bit tone periods, voice 0 lowest |
| noisePeriod | output | 5 | noise period |
| mixerEn | output | 6 | mixer enable bits |
| ampLevel | output | 15 | three 5-bit amplitude controls, voice 0 lowest |
| envPeriod | output | 16 | envelope period |
| envShape | output | 4 | envelope shape |

## Verification
The bench builds the block with the default SEL_CODE of 0. With that value every latch byte whose upper nibble is nonzero exercises the deselect path, and latches in the range 0x00 to 0x0F reach all sixteen registers. This covers each masked width, both port directions, and every control code with the qualifier low, so each of them is set against a register of known contents.

// File: rtl/sgbus_pkg.sv
package sgbus_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 4;
  localparam int NUM_REGS = 1 << ADDR_W;
  localparam int SEL_W    = DATA_W - ADDR_W;
  localparam int VOICES   = 3;
  localparam int TONE_W   = 12;
  localparam int AMP_W    = 5;

  localparam int ADDR_NOISE = 6;
  localparam int ADDR_MIXER = 7;
  localparam int ADDR_AMP0  = 8;
  localparam int ADDR_ENVLO = 11;
  localparam int ADDR_ENVHI = 12;
  localparam int ADDR_SHAPE = 13;
  localparam int ADDR_PORTA = 14;
  localparam int ADDR_PORTB = 15;
  localparam int DIR_A_BIT  = 6;
  localparam int DIR_B_BIT  = 7;

  typedef enum logic [1:0] {OP_IDLE, OP_READ, OP_WRITE, OP_LATCH} busOp_t;

  typedef struct packed {
    logic              wrEn;
    logic              rdEn;
    logic [ADDR_W-1:0] addr;
  } regStrobe_t;

  // Storage width of each register, as a keep-mask
  function automatic logic [DATA_W-1:0] regMask(input int unsigned a);
    if (a == 1 || a == 3 || a == 5 || a == ADDR_SHAPE) return 8'h0F;
    if (a == ADDR_NOISE || (a >= ADDR_AMP0 && a < ADDR_AMP0 + VOICES)) return 8'h1F;
    return 8'hFF;
  endfunction
endpackage

// File: rtl/sgbus_ctrl.sv
module sgbus_ctrl
  import sgbus_pkg::*;
#(
  parameter int SEL_CODE = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busDir,
  input  logic              busCtl2,
  input  logic              busCtl1,
  input  logic [DATA_W-1:0] busIn,
  output regStrobe_t        strobe,
  output logic              selected
);
  localparam logic [SEL_W-1:0] SEL_VAL = SEL_W'(SEL_CODE);

  busOp_t            op;
  logic [ADDR_W-1:0] addrQ;

  always_comb begin
    op = OP_IDLE;
    if (busCtl2) begin
      unique case ({busDir, busCtl1})
        2'b01:   op = OP_READ;
        2'b10:   op = OP_WRITE;
        2'b11:   op = OP_LATCH;
        default: op = OP_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ    <= '0;
      selected <= 1'b1;
    end else if (op == OP_LATCH) begin
      addrQ    <= busIn[ADDR_W-1:0];
      selected <= (busIn[DATA_W-1:ADDR_W] == SEL_VAL);
    end
  end

  always_comb begin
    strobe.wrEn = (op == OP_WRITE) && selected;
    strobe.rdEn = (op == OP_READ) && selected;
    strobe.addr = addrQ;
  end
endmodule

// File: rtl/sgbus_regs.sv
module sgbus_regs
  import sgbus_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  regStrobe_t              strobe,
  input  logic [DATA_W-1:0]       busIn,
  output logic [DATA_W-1:0]       busOut,
  output logic                    busOe,
  input  logic [DATA_W-1:0]       portAIn,
  output logic [DATA_W-1:0]       portAOut,
  output logic                    portAOe,
  input  logic [DATA_W-1:0]       portBIn,
  output logic [DATA_W-1:0]       portBOut,
  output logic                    portBOe,
  output logic [VOICES*TONE_W-1:0] tonePeriod,
  output logic [4:0]              noisePeriod,
  output logic [5:0]              mixerEn,
  output logic [VOICES*AMP_W-1:0] ampLevel,
  output logic [2*DATA_W-1:0]     envPeriod,
  output logic [3:0]              envShape
);
  logic [DATA_W-1:0] regQ [NUM_REGS];
  logic [DATA_W-1:0] rdVal;

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_REGS; i++) begin
      if (!rstN) regQ[i] <= '0;
      else if (strobe.wrEn && strobe.addr == ADDR_W'(i)) regQ[i] <= busIn & regMask(i);
    end
  end

  assign portAOe  = regQ[ADDR_MIXER][DIR_A_BIT];
  assign portBOe  = regQ[ADDR_MIXER][DIR_B_BIT];
  assign portAOut = regQ[ADDR_PORTA];
  assign portBOut = regQ[ADDR_PORTB];

  always_comb begin
    rdVal = regQ[strobe.addr];
    if (strobe.addr == ADDR_W'(ADDR_PORTA) && !portAOe) rdVal = portAIn;
    if (strobe.addr == ADDR_W'(ADDR_PORTB) && !portBOe) rdVal = portBIn;
  end

  assign busOe  = strobe.rdEn;
  assign busOut = strobe.rdEn ? rdVal : '0;

  for (genvar v = 0; v < VOICES; v++) begin : gVoice
    assign tonePeriod[v*TONE_W +: TONE_W] = {regQ[2*v+1][TONE_W-DATA_W-1:0], regQ[2*v]};
    assign ampLevel[v*AMP_W +: AMP_W]     = regQ[ADDR_AMP0+v][AMP_W-1:0];
  end

  assign noisePeriod = regQ[ADDR_NOISE][4:0];
  assign mixerEn     = regQ[ADDR_MIXER][5:0];
  assign envPeriod   = {regQ[ADDR_ENVHI], regQ[ADDR_ENVLO]};
  assign envShape    = regQ[ADDR_SHAPE][3:0];
endmodule

// File: rtl/sgbus_regfile.sv
module sgbus_regfile
  import sgbus_pkg::*;
#(
  parameter int SEL_CODE = 0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     busDir,
  input  logic                     busCtl2,
  input  logic                     busCtl1,
  input  logic [DATA_W-1:0]        busIn,
  output logic [DATA_W-1:0]        busOut,
  output logic                     busOe,
  input  logic [DATA_W-1:0]        portAIn,
  output logic [DATA_W-1:0]        portAOut,
  output logic                     portAOe,
  input  logic [DATA_W-1:0]        portBIn,
  output logic [DATA_W-1:0]        portBOut,
  output logic                     portBOe,
  output logic [VOICES*TONE_W-1:0] tonePeriod,
  output logic [4:0]               noisePeriod,
  output logic [5:0]               mixerEn,
  output logic [VOICES*AMP_W-1:0]  ampLevel,
  output logic [2*DATA_W-1:0]      envPeriod,
  output logic [3:0]               envShape
);
  regStrobe_t strobe;
  logic       selected;

  sgbus_ctrl #(.SEL_CODE(SEL_CODE)) uCtrl (
    .clk(clk), .rstN(rstN), .busDir(busDir), .busCtl2(busCtl2), .busCtl1(busCtl1),
    .busIn(busIn), .strobe(strobe), .selected(selected)
  );

  sgbus_regs uRegs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busIn(busIn),
    .busOut(busOut), .busOe(busOe),
    .portAIn(portAIn), .portAOut(portAOut), .portAOe(portAOe),
    .portBIn(portBIn), .portBOut(portBOut), .portBOe(portBOe),
    .tonePeriod(tonePeriod), .noisePeriod(noisePeriod), .mixerEn(mixerEn),
    .ampLevel(ampLevel), .envPeriod(envPeriod), .envShape(envShape)
  );
endmodule

// File: rtl/sgbus_checker.sv
module sgbus_checker
  import sgbus_pkg::*;
#(
  parameter int SEL_CODE = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic              busDir,
  input logic              busCtl2,
  input logic              busCtl1,
  input logic [DATA_W-1:0] busIn,
  input logic [DATA_W-1:0] busOut,
  input logic              busOe,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic              selected,
  input logic [5:0]        mixerEn,
  input logic [DATA_W-1:0] portAIn,
  input logic              portAOe
);
  localparam logic [SEL_W-1:0] SEL_VAL = SEL_W'(SEL_CODE);

  assert_wr_code_R1: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (busDir && busCtl2 && !busCtl1));

  assert_latch_addr_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busDir && busCtl2 && busCtl1) |=> addr == $past(busIn[ADDR_W-1:0]));

  assert_latch_sel_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busDir && busCtl2 && busCtl1) |=> selected == ($past(busIn[DATA_W-1:ADDR_W]) == SEL_VAL));

  assert_desel_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    !selected |-> (!wrEn && !busOe));

  assert_read_drive_R4: assert property (@(posedge clk) disable iff (!rstN)
    busOe |-> (!busDir && busCtl2 && busCtl1 && selected));

  assert_bus_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    !busOe |-> busOut == '0);

  assert_port_live_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busOe && addr == ADDR_W'(ADDR_PORTA) && !portAOe) |-> busOut == portAIn);

  assert_mixer_view_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(ADDR_MIXER)) |=> mixerEn == $past(busIn[5:0]));
endmodule

bind sgbus_regfile sgbus_checker #(.SEL_CODE(SEL_CODE)) uChk (
  .clk(clk), .rstN(rstN), .busDir(busDir), .busCtl2(busCtl2), .busCtl1(busCtl1),
  .busIn(busIn), .busOut(busOut), .busOe(busOe), .wrEn(strobe.wrEn),
  .addr(strobe.addr), .selected(selected), .mixerEn(mixerEn),
  .portAIn(portAIn), .portAOe(portAOe)
);

// File: tb/tb_sgbus_regfile.sv
module tb_sgbus_regfile;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busDir = 1'b0, busCtl2 = 1'b0, busCtl1 = 1'b0;
  logic [7:0]  busIn = '0;
  logic [7:0]  busOut;
  logic        busOe;
  logic [7:0]  portAIn = '0, portBIn = '0;
  logic [7:0]  portAOut, portBOut;
  logic        portAOe, portBOe;
  logic [35:0] tonePeriod;
  logic [4:0]  noisePeriod;
  logic [5:0]  mixerEn;
  logic [14:0] ampLevel;
  logic [15:0] envPeriod;
  logic [3:0]  envShape;

  int total = 0;
  int bad = 0;

  sgbus_regfile dut (
    .clk(clk), .rstN(rstN), .busDir(busDir), .busCtl2(busCtl2), .busCtl1(busCtl1),
    .busIn(busIn), .busOut(busOut), .busOe(busOe),
    .portAIn(portAIn), .portAOut(portAOut), .portAOe(portAOe),
    .portBIn(portBIn), .portBOut(portBOut), .portBOe(portBOe),
    .tonePeriod(tonePeriod), .noisePeriod(noisePeriod), .mixerEn(mixerEn),
    .ampLevel(ampLevel), .envPeriod(envPeriod), .envShape(envShape)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expMask(input int a);
    case (a)
      1, 3, 5, 13:  return 8'h0F;
      6, 8, 9, 10:  return 8'h1F;
      default:      return 8'hFF;
    endcase
  endfunction

  task automatic drive(input logic d, input logic c2, input logic c1, input logic [7:0] v);
    @(negedge clk);
    busDir = d; busCtl2 = c2; busCtl1 = c1; busIn = v;
  endtask

  task automatic goIdle();
    @(negedge clk);
    busDir = 1'b0; busCtl2 = 1'b1; busCtl1 = 1'b0; busIn = '0;
  endtask

  task automatic latchAddr(input logic [7:0] a);
    drive(1'b1, 1'b1, 1'b1, a); goIdle();
  endtask

  task automatic writeData(input logic [7:0] v);
    drive(1'b1, 1'b1, 1'b0, v); goIdle();
  endtask

  task automatic readData(output logic [7:0] v, output logic oe);
    drive(1'b0, 1'b1, 1'b1, 8'h00);
    #1; v = busOut; oe = busOe;
    goIdle();
  endtask

  task automatic writeReg(input int a, input logic [7:0] v);
    latchAddr(8'(a)); writeData(v);
  endtask

  task automatic readReg(input int a, output logic [7:0] v);
    logic oe;
    latchAddr(8'(a)); readData(v, oe);
  endtask

  task automatic t_reset();
    logic [7:0] v; logic oe;
    #1;
    check(busOe == 1'b0, "R9 bus released after reset", busOe, 0);
    check(tonePeriod == 0 && envPeriod == 0 && mixerEn == 0, "R9 view zero", tonePeriod, 0);
    readData(v, oe);
    check(oe == 1'b1 && v == 8'h00, "R9 addr0 selected reads zero", {oe, v}, 9'h100);
    #1;
    check(busOe == 1'b0 && busOut == 8'h00, "R4 idle releases bus", {busOe, busOut}, 0);
  endtask

  task automatic t_masks();
    logic [7:0] v;
    for (int a = 0; a < 16; a++) writeReg(a, 8'hFF);
    for (int a = 0; a < 16; a++) begin
      readReg(a, v);
      check(v == expMask(a), $sformatf("R5 mask addr %0d", a), v, expMask(a));
    end
    for (int a = 0; a < 16; a++) begin
      logic [7:0] p;
      p = 8'((a * 37 + 91) & 255);
      if (a == 7) p = p | 8'hC0;
      writeReg(a, p);
    end
    for (int a = 0; a < 16; a++) begin
      logic [7:0] p;
      p = 8'((a * 37 + 91) & 255);
      if (a == 7) p = p | 8'hC0;
      readReg(a, v);
      check(v == (p & expMask(a)), $sformatf("R3 R4 pattern addr %0d", a), v, p & expMask(a));
    end
  endtask

  task automatic t_view();
    writeReg(0, 8'h34); writeReg(1, 8'hF2);
    writeReg(2, 8'hAB); writeReg(3, 8'h0C);
    writeReg(4, 8'h01); writeReg(5, 8'h7F);
    writeReg(6, 8'hFE); writeReg(7, 8'h2A);
    writeReg(8, 8'h13); writeReg(9, 8'hE4); writeReg(10, 8'h1F);
    writeReg(11, 8'h5A); writeReg(12, 8'hC3); writeReg(13, 8'h39);
    #1;
    check(tonePeriod == {12'hF01, 12'hCAB, 12'h234}, "R8 tone periods", tonePeriod, {12'hF01, 12'hCAB, 12'h234});
    check(noisePeriod == 5'h1E && mixerEn == 6'h2A, "R8 noise mixer", {noisePeriod, mixerEn}, {5'h1E, 6'h2A});
    check(ampLevel == {5'h1F, 5'h04, 5'h13}, "R8 amplitudes", ampLevel, {5'h1F, 5'h04, 5'h13});
    check(envPeriod == 16'hC35A && envShape == 4'h9, "R8 envelope", {envPeriod, envShape}, {16'hC35A, 4'h9});
    writeReg(14, 8'h11); writeReg(15, 8'h22);
    #1;
    check(tonePeriod == {12'hF01, 12'hCAB, 12'h234} && envPeriod == 16'hC35A && ampLevel == {5'h1F, 5'h04, 5'h13},
          "R8 port writes leave view", tonePeriod, {12'hF01, 12'hCAB, 12'h234});
  endtask

  task automatic t_decode();
    logic [7:0] v;
    writeReg(9, 8'h0A);
    for (int c = 0; c < 4; c++) begin
      drive(c[1], 1'b0, c[0], 8'h1F);
      #1;
      check(busOe == 1'b0, $sformatf("R1 qualifier low code %0d no drive", c), busOe, 0);
    end
    goIdle();
    readReg(9, v);
    check(v == 8'h0A, "R1 qualifier low no write", v, 8'h0A);
    latchAddr(8'h09);
    drive(1'b1, 1'b0, 1'b1, 8'h02); goIdle();
    writeData(8'h11);
    readReg(9, v);
    check(v == 8'h11, "R1 qualifier low no latch", v, 8'h11);
  endtask

  task automatic t_desel();
    logic [7:0] v; logic oe;
    writeReg(3, 8'h05);
    latchAddr(8'h23);
    writeData(8'h0E);
    readData(v, oe);
    check(oe == 1'b0, "R2 deselected read no drive", oe, 0);
    latchAddr(8'hF3);
    writeData(8'h0D);
    readReg(3, v);
    check(v == 8'h05, "R2 deselected write dropped", v, 8'h05);
  endtask

  task automatic t_ports();
    logic [7:0] v;
    writeReg(7, 8'h00);
    portAIn = 8'h3C; portBIn = 8'hA5;
    writeReg(14, 8'h99);
    #1;
    check(portAOe == 1'b0 && portBOe == 1'b0, "R6 both inputs", {portAOe, portBOe}, 0);
    readReg(14, v);
    check(v == 8'h3C, "R7 port A live pins", v, 8'h3C);
    writeReg(7, 8'h40);
    #1;
    check(portAOe == 1'b1 && portAOut == 8'h99 && portBOe == 1'b0, "R6 port A output", {portAOe, portAOut}, {1'b1, 8'h99});
    readReg(14, v);
    check(v == 8'h99, "R7 stored byte after switch", v, 8'h99);
    writeReg(15, 8'h66);
    readReg(15, v);
    check(v == 8'hA5, "R7 port B live pins", v, 8'hA5);
    writeReg(7, 8'h80);
    #1;
    check(portBOe == 1'b1 && portBOut == 8'h66 && portAOe == 1'b0, "R6 port B output", {portBOe, portBOut}, {1'b1, 8'h66});
    readReg(15, v);
    check(v == 8'h66, "R6 port B read stored", v, 8'h66);
  endtask

  task automatic t_persist();
    logic [7:0] v; logic oe;
    latchAddr(8'h0B);
    writeData(8'h12);
    writeData(8'h34);
    readData(v, oe);
    check(v == 8'h34, "R10 address held first read", v, 8'h34);
    readData(v, oe);
    check(v == 8'h34 && oe, "R10 address held second read", v, 8'h34);
    writeData(8'h56);
    readData(v, oe);
    check(v == 8'h56, "R10 write after reads", v, 8'h56);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_masks();
    t_view();
    t_decode();
    t_desel();
    t_ports();
    t_persist();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule